// File: doc/BRIEF.md
# Byte-Lane Width-Converting Stream Buffer

This block sits between the reading side and the writing side of a DMA stream and holds up to 16 bytes in flight. Each side names its own item size (byte, half-word or word) on every access. Bytes are stored individually in a circular byte-lane store, so a narrow source can fill a wide destination item, and a wide source item can be drained as several narrow ones. The order is little-endian: the byte written first leaves on the lowest lane.

The source pushes with `src_valid`/`src_ready` and the destination takes items with `dst_ready`/`dst_valid`. Each handshake is an offer held for a single cycle. `src_ready` is high when the free space covers one item of the current source size. `dst_valid` is high when the stored bytes cover one item of the current destination size. A side that raises its strobe while the other half of its handshake is low breaks the protocol. That access is dropped and the sticky buffer error flag is set. Two more flags tell the address sequencer when a whole burst of 1, 4, 8 or 16 beats can run without stalling, one flag for each side. In direct mode no width conversion is allowed. Any access while the two sizes differ is dropped and sets a sticky direct-mode error. A flush input empties the buffer and clears both error flags.

Top module: `dmapk_fifo`

## Requirements
- R1: After reset, `level` is 0, `src_ready` is 1, `dst_valid` is 0, and `fifo_err` and `dm_err` are 0.
- R2: Size codes are 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, and 2'b11 is taken as 4 bytes. An accepted push (`src_valid` and `src_ready`) raises `level` by the source size in the next cycle. `src_ready` is high exactly when 16 − `level` is at least the source size.
- R3: Packing: bytes leave in the order they were written. Byte k of a destination item appears on `dst_data[8k+7:8k]`, and lanes above the destination size read as zero.
- R4: Unpacking: a wide pushed item is read out as narrower items, starting with its least significant byte or half-word.
- R5: `dst_valid` is high exactly when `level` is at least the destination size. An accepted pop lowers `level` by that size.
- R6: `src_valid` while `src_ready` is low sets `fifo_err`, and the item is discarded without changing `level` or the stored data.
- R7: `dst_ready` while `dst_valid` is low sets `fifo_err` and leaves `level` unchanged.
- R8: With `burst_sel` 0/1/2/3 meaning 1/4/8/16 beats, `dst_burst_ok` is high when `level` is at least beats × destination size. `src_burst_ok` is high when the free space is at least beats × source size. Neither flag can be high when that product exceeds 16.
- R9: `flush` sets `level` to 0, clears `fifo_err` and `dm_err`, and overrides any push or pop in the same cycle.
- R10: With `direct_mode` high and `src_size` ≠ `dst_size`, any `src_valid` or `dst_ready` sets `dm_err` and is dropped. With equal sizes, direct mode moves data as usual.
- R11: A push and a pop in the same cycle change `level` by the pushed size minus the popped size, and the data order is kept.
- R12: `fifo_err` and `dm_err` stay set until a flush.
- R13: Data is stored correctly across the wrap of the 16-byte circular store, including an item that is split across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all contents and clear errors |
| direct_mode | input | 1 | Forbid width conversion |
| burst_sel | input | 2 | Burst length select: 1, 4, 8 or 16 beats |
| src_size | input | 2 | Source item size code |
| src_valid | input | 1 | Source push strobe |
| src_data | input | 32 | Source item, little-endian lanes |
| src_ready | output | 1 | Room for one source item |
| dst_size | input | 2 | Destination item size code |
| dst_ready | input | 1 | Destination pop strobe |
| dst_valid | output | 1 | One destination item available |
| dst_data | output | 32 | Assembled destination item |
| level | output | 5 | Bytes held |
| src_burst_ok | output | 1 | Room for a full source burst |
| dst_burst_ok | output | 1 | Data for a full destination burst |
| fifo_err | output | 1 | Sticky overflow/underflow flag |
| dm_err | output | 1 | Sticky direct-mode size mismatch flag |

## Verification
The bench aims at byte order first, using mixed sizes in both directions. A design with the lanes swapped would return a word as 0x11223344 instead of 0x44332211. The wrap of the circular store is tested with a word split across lanes 15 and 0, which a design with a bad pointer would corrupt. Protocol abuse is covered: a push into a full buffer and a pop of a word while only one byte is held must both set the error and leave `level` alone. A design that accepted either would change the data or the count. Burst flags are tested at one byte below and exactly at the threshold, and for a 64-byte request that can never fit. A flush in the same cycle as a push, simultaneous push and pop, and a size mismatch in direct mode complete the set.

// File: rtl/dmapk_pkg.sv
package dmapk_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  // Bytes carried by one item of the given size code; the spare code acts as word.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (xfer_size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Beats in one burst for the burst select code.
  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    burst_beats = 5'd1;
      2'd1:    burst_beats = 5'd4;
      2'd2:    burst_beats = 5'd8;
      default: burst_beats = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dmapk_lane_store.sv
module dmapk_lane_store #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [2:0]         wr_cnt,
  input  logic [8*LANES-1:0] wr_data,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic [2:0]         rd_cnt,
  output logic [8*LANES-1:0] rd_data
);

  logic [7:0] lane_q [DEPTH];

  // Each incoming lane lands at its own circular byte address.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(wr_cnt)) lane_q[wr_ptr + PTR_W'(i)] <= wr_data[8*i +: 8];
      end
    end
  end

  // Assemble the outgoing item; lanes beyond the requested size are zero.
  for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
    always_comb begin
      if (g < int'(rd_cnt)) rd_data[8*g +: 8] = lane_q[rd_ptr + PTR_W'(g)];
      else                  rd_data[8*g +: 8] = '0;
    end
  end

endmodule

// File: rtl/dmapk_level_ctrl.sv
module dmapk_level_ctrl
  import dmapk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [2:0]       src_n,
  input  logic [2:0]       dst_n,
  input  logic [1:0]       burst_sel,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             has_room,
  output logic             has_item,
  output logic             src_burst,
  output logic             dst_burst
);

  int free_b;
  int src_need;
  int dst_need;

  always_comb begin
    free_b   = DEPTH - int'(count);
    src_need = int'(burst_beats(burst_sel)) * int'(src_n);
    dst_need = int'(burst_beats(burst_sel)) * int'(dst_n);
    has_room  = free_b >= int'(src_n);
    has_item  = int'(count) >= int'(dst_n);
    src_burst = (src_need <= DEPTH) && (free_b >= src_need);
    dst_burst = (dst_need <= DEPTH) && (int'(count) >= dst_need);
  end

  logic [CNT_W-1:0] add_b, sub_b;
  assign add_b = push_ok ? CNT_W'(src_n) : '0;
  assign sub_b = pop_ok  ? CNT_W'(dst_n) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      count <= count + add_b - sub_b;
      if (push_ok) wr_ptr <= wr_ptr + PTR_W'(src_n);
      if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(dst_n);
    end
  end

endmodule

// File: rtl/dmapk_err_track.sv
module dmapk_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic ovf_hit,
  input  logic unf_hit,
  input  logic mismatch_hit,
  output logic fifo_err,
  output logic dm_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_err <= 1'b0;
      dm_err   <= 1'b0;
    end else if (flush) begin
      fifo_err <= 1'b0;
      dm_err   <= 1'b0;
    end else begin
      if (ovf_hit || unf_hit) fifo_err <= 1'b1;
      if (mismatch_hit)       dm_err   <= 1'b1;
    end
  end

endmodule

// File: rtl/dmapk_fifo.sv
module dmapk_fifo
  import dmapk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              direct_mode,
  input  logic [1:0]        burst_sel,
  input  logic [1:0]        src_size,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic [1:0]        dst_size,
  input  logic              dst_ready,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  output logic [CNT_W-1:0]  level,
  output logic              src_burst_ok,
  output logic              dst_burst_ok,
  output logic              fifo_err,
  output logic              dm_err
);

  logic [2:0]       src_n, dst_n;
  logic             size_clash;
  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign src_n      = size_bytes(src_size);
  assign dst_n      = size_bytes(dst_size);
  assign size_clash = direct_mode && (src_size != dst_size);
  assign push_ok    = src_valid && src_ready && !size_clash && !flush;
  assign pop_ok     = dst_ready && dst_valid && !size_clash && !flush;

  dmapk_level_ctrl #(.DEPTH(DEPTH)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .src_n     (src_n),
    .dst_n     (dst_n),
    .burst_sel (burst_sel),
    .count     (level),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .has_room  (src_ready),
    .has_item  (dst_valid),
    .src_burst (src_burst_ok),
    .dst_burst (dst_burst_ok)
  );

  dmapk_lane_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_ptr  (wr_ptr),
    .wr_cnt  (src_n),
    .wr_data (src_data),
    .rd_ptr  (rd_ptr),
    .rd_cnt  (dst_n),
    .rd_data (dst_data)
  );

  dmapk_err_track u_err (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .ovf_hit      (src_valid && !src_ready),
    .unf_hit      (dst_ready && !dst_valid),
    .mismatch_hit (size_clash && (src_valid || dst_ready)),
    .fifo_err     (fifo_err),
    .dm_err       (dm_err)
  );

endmodule

// File: rtl/dmapk_fifo_chk.sv
module dmapk_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             direct_mode,
  input logic [1:0]       src_size,
  input logic             src_valid,
  input logic             src_ready,
  input logic [1:0]       dst_size,
  input logic             dst_ready,
  input logic             dst_valid,
  input logic [CNT_W-1:0] level,
  input logic             fifo_err,
  input logic             dm_err
);

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  logic clash;
  assign clash = direct_mode && (src_size != dst_size);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && !dst_ready && !flush && !clash)
    |=> int'(level) == int'($past(level)) + nbytes($past(src_size)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready && !dst_ready && !flush) |=> (fifo_err && $stable(level)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_ready && !dst_valid && !src_valid && !flush) |=> (fifo_err && $stable(level)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !fifo_err && !dm_err));

  p_clash_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && (src_valid || dst_ready) && !flush) |=> (dm_err && $stable(level)));

  p_sticky_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_err || dm_err) && !flush) |=> ($stable(fifo_err) || fifo_err) && (dm_err || !$past(dm_err)));

endmodule

bind dmapk_fifo dmapk_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .direct_mode (direct_mode),
  .src_size    (src_size),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .dst_size    (dst_size),
  .dst_ready   (dst_ready),
  .dst_valid   (dst_valid),
  .level       (level),
  .fifo_err    (fifo_err),
  .dm_err      (dm_err)
);

// File: tb/dmapk_fifo_bench.sv
module dmapk_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        direct_mode = 1'b0;
  logic [1:0]  burst_sel = 2'd0;
  logic [1:0]  src_size = 2'd0;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready;
  logic [1:0]  dst_size = 2'd0;
  logic        dst_ready = 1'b0;
  logic        dst_valid;
  logic [31:0] dst_data;
  logic [4:0]  level;
  logic        src_burst_ok, dst_burst_ok, fifo_err, dm_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmapk_fifo u_dmapk_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .direct_mode(direct_mode),
    .burst_sel(burst_sel), .src_size(src_size), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .dst_size(dst_size),
    .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_data(dst_data),
    .level(level), .src_burst_ok(src_burst_ok), .dst_burst_ok(dst_burst_ok),
    .fifo_err(fifo_err), .dm_err(dm_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [1:0] sz, input logic [31:0] d);
    src_size = sz; src_data = d; src_valid = 1'b1;
    tick();
    src_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [1:0] sz, input logic [31:0] exp, input string tag);
    dst_size = sz;
    #1;
    chk(tag, dst_data, exp);
    dst_ready = 1'b1;
    tick();
    dst_ready = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", 32'(level), 0);
    chk("R1 src_ready", 32'(src_ready), 1);
    chk("R1 dst_valid", 32'(dst_valid), 0);
    chk("R1 errors", {30'd0, fifo_err, dm_err}, 0);
  endtask

  task automatic t_pack();
    push(2'b00, 32'h11); push(2'b00, 32'h22); push(2'b00, 32'h33); push(2'b00, 32'h44);
    chk("R2 level after four bytes", 32'(level), 4);
    dst_size = 2'b10; #1;
    chk("R5 word valid", 32'(dst_valid), 1);
    pop_chk(2'b10, 32'h44332211, "R3 bytes packed to word");
    chk("R5 level after pop", 32'(level), 0);
    push(2'b01, 32'hBEEF); push(2'b01, 32'hCAFE);
    pop_chk(2'b10, 32'hCAFEBEEF, "R3 halves packed to word");
    push(2'b11, 32'h0A0B0C0D);
    chk("R2 reserved code adds four", 32'(level), 4);
    pop_chk(2'b00, 32'h0D, "R3 upper lanes zero");
    do_flush();
  endtask

  task automatic t_unpack();
    push(2'b10, 32'hAABBCCDD);
    pop_chk(2'b00, 32'hDD, "R4 byte 0");
    pop_chk(2'b00, 32'hCC, "R4 byte 1");
    pop_chk(2'b00, 32'hBB, "R4 byte 2");
    pop_chk(2'b00, 32'hAA, "R4 byte 3");
    push(2'b10, 32'h12345678);
    pop_chk(2'b01, 32'h5678, "R4 low half");
    pop_chk(2'b01, 32'h1234, "R4 high half");
    chk("R5 empty after unpack", 32'(dst_valid), 0);
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 4; i++) push(2'b10, 32'h01010101 * i);
    chk("R2 full level", 32'(level), 16);
    chk("R2 ready low when full", 32'(src_ready), 0);
    push(2'b10, 32'hDEADBEEF);
    chk("R6 overflow flag", 32'(fifo_err), 1);
    chk("R6 level unchanged", 32'(level), 16);
    tick(); tick(); tick();
    chk("R12 fifo_err sticky", 32'(fifo_err), 1);
    for (int i = 1; i <= 4; i++) pop_chk(2'b10, 32'h01010101 * i, "R6 contents intact");
    chk("R6 dropped item absent", 32'(dst_valid), 0);
    do_flush();
    chk("R9 flush clears fifo_err", 32'(fifo_err), 0);
  endtask

  task automatic t_underflow();
    dst_size = 2'b10; dst_ready = 1'b1;
    tick(); dst_ready = 1'b0;
    chk("R7 underflow when empty", 32'(fifo_err), 1);
    chk("R7 level stays 0", 32'(level), 0);
    do_flush();
    push(2'b00, 32'h77);
    dst_size = 2'b10; #1;
    chk("R5 one byte not a word", 32'(dst_valid), 0);
    dst_ready = 1'b1; tick(); dst_ready = 1'b0;
    chk("R7 partial underflow flag", 32'(fifo_err), 1);
    chk("R7 partial level kept", 32'(level), 1);
    pop_chk(2'b00, 32'h77, "R7 byte survives");
    do_flush();
  endtask

  task automatic t_burst();
    burst_sel = 2'd1; dst_size = 2'b00;
    push(2'b00, 32'h1); push(2'b00, 32'h2); push(2'b00, 32'h3);
    chk("R8 dst burst below threshold", 32'(dst_burst_ok), 0);
    push(2'b00, 32'h4);
    chk("R8 dst burst at threshold", 32'(dst_burst_ok), 1);
    src_size = 2'b10; #1;
    chk("R8 src burst of 16 bytes no room", 32'(src_burst_ok), 0);
    burst_sel = 2'd2; dst_size = 2'b01; #1;
    chk("R8 8 halves not ready", 32'(dst_burst_ok), 0);
    do_flush();
    src_size = 2'b10; burst_sel = 2'd1; #1;
    chk("R8 src burst room when empty", 32'(src_burst_ok), 1);
    for (int i = 0; i < 4; i++) push(2'b10, 32'h0);
    burst_sel = 2'd3; dst_size = 2'b10; #1;
    chk("R8 64-byte burst never fits", 32'(dst_burst_ok), 0);
    burst_sel = 2'd3; dst_size = 2'b00; #1;
    chk("R8 16 byte burst full", 32'(dst_burst_ok), 1);
    burst_sel = 2'd0;
    do_flush();
  endtask

  task automatic t_simul_wrap();
    push(2'b10, 32'h04030201);
    src_size = 2'b10; src_data = 32'h08070605; src_valid = 1'b1;
    dst_size = 2'b01; dst_ready = 1'b1;
    tick(); src_valid = 1'b0; dst_ready = 1'b0;
    chk("R11 level push4 pop2", 32'(level), 6);
    pop_chk(2'b10, 32'h06050403, "R11 order kept");
    pop_chk(2'b01, 32'h0807, "R11 tail");
    do_flush();
    for (int i = 0; i < 3; i++) push(2'b10, 32'h0);
    for (int i = 0; i < 3; i++) pop_chk(2'b10, 32'h0, "R13 pre-fill");
    push(2'b10, 32'hA1A2A3A4); push(2'b10, 32'hB1B2B3B4); push(2'b00, 32'hC5);
    pop_chk(2'b01, 32'hA3A4, "R13 half before wrap");
    pop_chk(2'b10, 32'hB3B4A1A2, "R13 word across wrap");
    pop_chk(2'b01, 32'hB1B2, "R13 half after wrap");
    pop_chk(2'b00, 32'hC5, "R13 last byte");
    do_flush();
  endtask

  task automatic t_direct();
    direct_mode = 1'b1; dst_size = 2'b10;
    push(2'b00, 32'h99);
    chk("R10 mismatch flag", 32'(dm_err), 1);
    chk("R10 mismatch push dropped", 32'(level), 0);
    chk("R10 no fifo error", 32'(fifo_err), 0);
    tick();
    chk("R12 dm_err sticky", 32'(dm_err), 1);
    do_flush();
    chk("R9 flush clears dm_err", 32'(dm_err), 0);
    dst_size = 2'b01;
    push(2'b01, 32'h5A3C);
    chk("R10 equal sizes accepted", 32'(level), 2);
    chk("R10 no flag when equal", 32'(dm_err), 0);
    dst_size = 2'b00; dst_ready = 1'b1; tick(); dst_ready = 1'b0;
    chk("R10 mismatch pop flag", 32'(dm_err), 1);
    chk("R10 mismatch pop dropped", 32'(level), 2);
    pop_chk(2'b01, 32'h5A3C, "R10 data in direct mode");
    direct_mode = 1'b0;
    do_flush();
  endtask

  task automatic t_flush_prio();
    push(2'b10, 32'h1);
    flush = 1'b1; src_size = 2'b10; src_valid = 1'b1;
    tick(); flush = 1'b0; src_valid = 1'b0;
    chk("R9 flush overrides push", 32'(level), 0);
    chk("R9 ready after flush", 32'(src_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    t_reset();
    t_pack();
    t_unpack();
    t_overflow();
    t_underflow();
    t_burst();
    t_simul_wrap();
    t_direct();
    t_flush_prio();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule